// File: doc/BRIEF.md
# Line-Tagged Shared Receive Queue

This block is a single circular receive queue that four serial line receivers share. Each receiver presents an 8-bit character together with its 2-bit line number and a push strobe; the queue stores both so that software reading one register can tell which line each character came from. A pop, issued when software reads the receive register, yields one packed word. That word carries a valid flag, the source line and the character, and is registered one cycle after the pop.

One line is designated as low priority, intended for a pointer device such as a mouse that can flood the queue. Once more than half the entries are occupied, pushes from that line are silently discarded, while the other lines keep the remaining space. The block reports occupancy, empty and not-empty. It raises a sticky overrun flag when a push leaves the write pointer sitting on the read pointer, which means the queue is full. The depth and the low-priority line number are parameters.

Top module: `line_rx_fifo`

## Requirements
- R1: While rst_ni is low and after its release, count_o is 0, empty_o is 1, not_empty_o is 0, overrun_o is 0 and rd_word_o is 0.
- R2: Entries leave in the order they were accepted, each with the character and line number it was pushed with.
- R3: A pop on a non-empty queue makes rd_word_o, from the next clock edge onward, hold bit 15 = 1, bits [9:8] = line, bits [7:0] = character and bits [14:10] = 0; rd_word_o holds its value until the next pop.
- R4: A pop on an empty queue makes rd_word_o all zero from the next edge and leaves count_o unchanged.
- R5: The read and write positions wrap to zero after entry DEPTH-1, so a long stream of pushes and pops keeps its order and tags.
- R6: A push from line LOW_LINE (default 2) is discarded when count_o is greater than DEPTH/2 before the edge; at exactly DEPTH/2 it is accepted, and pushes from other lines are accepted whenever there is room. A discarded push does not touch overrun_o.
- R7: A push that is not discarded by R6 and after which the queue holds DEPTH entries sets overrun_o; the flag stays set until reset. A push into a full queue without a pop in the same cycle is dropped.
- R8: A push and a pop in the same cycle on a non-empty queue both take effect and count_o stays the same.
- R9: count_o equals the number of stored entries (0 to DEPTH), empty_o is 1 exactly when it is 0, and not_empty_o is the inverse of empty_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Push strobe from a line receiver |
| push_char_i | input | 8 | Received character |
| push_line_i | input | 2 | Line number of the received character |
| pop_i | input | 1 | Pop strobe from the receive-register read |
| rd_word_o | output | 16 | Packed popped word: valid, line, character |
| count_o | output | $clog2(DEPTH+1) | Number of stored entries |
| empty_o | output | 1 | Queue holds no entries |
| not_empty_o | output | 1 | Queue holds at least one entry |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
The assertions assume that push_line_i is meaningful only while push_i is high, and that pop_i is a single-cycle strobe per register read. They do not assume that pop is withheld when the queue is empty or that push is withheld when it is full. The stimulus therefore deliberately pops an empty queue, pushes into a full one, and pushes the low-priority line on both sides of the half-full threshold. All inputs change away from the active edge. A long mixed phase of concurrent pushes and pops then carries both positions around the ring several times.

// File: rtl/line_rx_fifo_pkg.sv
package line_rx_fifo_pkg;
  localparam int CHAR_W    = 8;
  localparam int LINE_W    = 2;
  localparam int WORD_W    = 16;
  localparam int VALID_BIT = WORD_W - 1;
  localparam int PAD_W     = WORD_W - 1 - LINE_W - CHAR_W;

  typedef struct packed {
    logic [LINE_W-1:0] line;
    logic [CHAR_W-1:0] ch;
  } rx_entry_t;

  function automatic logic [WORD_W-1:0] pack_word(input rx_entry_t e);
    return {1'b1, {PAD_W{1'b0}}, e.line, e.ch};
  endfunction
endpackage

// File: rtl/rx_ptr.sv
module rx_ptr #(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_o <= '0;
    else if (adv_i) ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
  end

  AST_PTR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && ptr_o == LAST |=> ptr_o == '0); // R5
  AST_PTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_o <= LAST); // R5
endmodule

// File: rtl/rx_store.sv
module rx_store
  import line_rx_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             wr_en_i,
  input  logic [PTR_W-1:0] wr_ptr_i,
  input  rx_entry_t        wr_entry_i,
  input  logic [PTR_W-1:0] rd_ptr_i,
  output rx_entry_t        rd_entry_o
);
  rx_entry_t slots [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (wr_en_i && wr_ptr_i == PTR_W'(i)) slots[i] <= wr_entry_i;
    end
  end

  assign rd_entry_o = slots[rd_ptr_i];
endmodule

// File: rtl/rx_admit.sv
module rx_admit #(
  parameter int DEPTH    = 8,
  parameter int LOW_LINE = 2,
  parameter int LINE_W   = 2,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic              push_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              pop_take_i,
  output logic              wr_en_o,
  output logic              ovr_set_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);

  logic filtered, live, room;

  // low-priority line loses once more than half is occupied
  assign filtered  = (line_i == LINE_W'(LOW_LINE)) && (count_i > HALF_CNT);
  assign live      = push_i && !filtered;
  assign room      = (count_i != FULL_CNT) || pop_take_i;
  assign wr_en_o   = live && room;
  // set whenever the push leaves the queue full
  assign ovr_set_o = live && ((count_i == FULL_CNT) ||
                              (count_i == FULL_CNT - 1'b1 && !pop_take_i));
endmodule

// File: rtl/line_rx_fifo.sv
module line_rx_fifo
  import line_rx_fifo_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int LOW_LINE = 2,
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [CHAR_W-1:0] push_char_i,
  input  logic [LINE_W-1:0] push_line_i,
  input  logic              pop_i,
  output logic [WORD_W-1:0] rd_word_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              empty_o,
  output logic              not_empty_o,
  output logic              overrun_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);

  logic             pop_take, wr_en, ovr_set;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  rx_entry_t        wr_entry, head;

  assign empty_o     = (count_o == '0);
  assign not_empty_o = !empty_o;
  assign pop_take    = pop_i && not_empty_o;
  assign wr_entry    = '{line: push_line_i, ch: push_char_i};

  rx_admit #(.DEPTH(DEPTH), .LOW_LINE(LOW_LINE), .LINE_W(LINE_W)) u_admit (
    .push_i    (push_i),
    .line_i    (push_line_i),
    .count_i   (count_o),
    .pop_take_i(pop_take),
    .wr_en_o   (wr_en),
    .ovr_set_o (ovr_set)
  );

  rx_ptr #(.DEPTH(DEPTH)) u_wr_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(wr_en), .ptr_o(wr_ptr)
  );

  rx_ptr #(.DEPTH(DEPTH)) u_rd_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(pop_take), .ptr_o(rd_ptr)
  );

  rx_store #(.DEPTH(DEPTH)) u_store (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en),
    .wr_ptr_i  (wr_ptr),
    .wr_entry_i(wr_entry),
    .rd_ptr_i  (rd_ptr),
    .rd_entry_o(head)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o   <= '0;
      overrun_o <= 1'b0;
      rd_word_o <= '0;
    end else begin
      case ({wr_en, pop_take})
        2'b10:   count_o <= count_o + 1'b1;
        2'b01:   count_o <= count_o - 1'b1;
        default: count_o <= count_o;
      endcase
      if (ovr_set) overrun_o <= 1'b1;
      if (pop_i)   rd_word_o <= pop_take ? pack_word(head) : '0;
    end
  end

  AST_CNT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= FULL_CNT); // R9
  AST_POP_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && not_empty_o |=> rd_word_o[VALID_BIT] && rd_word_o[WORD_W-2:CHAR_W+LINE_W] == '0); // R3
  AST_EMPTY_POP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && empty_o && !push_i |=> rd_word_o == '0 && count_o == '0); // R4
  AST_LOW_LINE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && push_line_i == LINE_W'(LOW_LINE) && count_o > HALF_CNT
    |=> count_o == $past(count_o) - CNT_W'($past(pop_i && not_empty_o))); // R6
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o); // R7
  AST_FULL_NO_GROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o == FULL_CNT && !pop_i |=> count_o == FULL_CNT); // R7
  AST_SAME_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && pop_i && not_empty_o && push_line_i != LINE_W'(LOW_LINE)
    |=> $stable(count_o)); // R8
endmodule

// File: tb/tb_line_rx_fifo.sv
`timescale 1ns/1ps
module tb_line_rx_fifo;
  localparam int DEPTH = 8;
  localparam int LOW   = 2;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          push_i = 1'b0, pop_i = 1'b0;
  logic [7:0]    push_char_i = '0;
  logic [1:0]    push_line_i = '0;
  logic [15:0]   rd_word_o;
  logic [CW-1:0] count_o;
  logic          empty_o, not_empty_o, overrun_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [9:0]  mq[$];
  logic [15:0] m_word = '0;
  bit          m_ovr = 0;

  always #2.5 clk_i = ~clk_i;

  line_rx_fifo #(.DEPTH(DEPTH), .LOW_LINE(LOW)) dut (.*);

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(rd_word_o == m_word, tag, "rd_word", rd_word_o, m_word);
    chk(count_o == CW'(mq.size()), "R9", "count", count_o, mq.size());
    chk(empty_o == (mq.size() == 0), "R9", "empty", empty_o, mq.size() == 0);
    chk(not_empty_o == (mq.size() != 0), "R9", "not_empty", not_empty_o, mq.size() != 0);
    chk(overrun_o == m_ovr, "R7", "overrun", overrun_o, m_ovr);
  endtask

  task automatic step(bit ps, logic [7:0] ch, logic [1:0] ln, bit pp, string tag);
    int  n;
    bit  took, filt;
    push_i = ps; push_char_i = ch; push_line_i = ln; pop_i = pp;
    @(posedge clk_i);
    n    = mq.size();
    filt = ps && ln == 2'(LOW) && n > DEPTH / 2;
    took = pp && n > 0;
    if (pp) m_word = took ? {1'b1, 5'b0, mq[0]} : 16'h0;
    if (took) void'(mq.pop_front());
    if (ps && !filt) begin
      if (mq.size() < DEPTH) mq.push_back({ln, ch});
      if (mq.size() == DEPTH) m_ovr = 1;
    end
    @(negedge clk_i);
    push_i = 0; pop_i = 0;
    compare(tag);
  endtask

  task automatic do_reset();
    rst_ni = 0;
    @(posedge clk_i);
    mq.delete(); m_word = '0; m_ovr = 0;
    @(negedge clk_i);
    compare("R1");
    rst_ni = 1;
    @(negedge clk_i);
    compare("R1");
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk_i);
    compare("R1");
    do_reset();

    // R2 R3: order and tags
    step(1, 8'h41, 2'd0, 0, "R2");
    step(1, 8'h9c, 2'd3, 0, "R2");
    step(1, 8'h07, 2'd2, 0, "R2");
    step(0, 0, 0, 1, "R3");
    step(0, 0, 0, 0, "R3");
    step(0, 0, 0, 1, "R2");
    step(0, 0, 0, 1, "R2");
    // R4: pop on empty
    step(0, 0, 0, 1, "R4");
    step(0, 0, 0, 1, "R4");

    // R8: same-cycle push and pop
    step(1, 8'h11, 2'd1, 0, "R8");
    step(1, 8'h22, 2'd3, 1, "R8");
    step(1, 8'h33, 2'd2, 1, "R8");
    step(1, 8'h44, 2'd1, 1, "R4");  // empty-edge check: pop with push of one
    step(0, 0, 0, 1, "R8");

    // R6: low-priority threshold
    for (int i = 0; i < 4; i++) step(1, 8'h50 + 8'(i), 2'(i == 2 ? 3 : i), 0, "R6");
    step(1, 8'h60, 2'd2, 0, "R6");   // count 4 == half: accepted
    step(1, 8'h61, 2'd2, 0, "R6");   // count 5: dropped
    step(1, 8'h62, 2'd1, 0, "R6");   // other line accepted
    step(1, 8'h63, 2'd2, 1, "R6");   // dropped even with pop
    for (int i = 0; i < 7; i++) step(0, 0, 0, 1, "R6");

    // R7: fill to full, overflow, sticky
    for (int i = 0; i < DEPTH - 1; i++) step(1, 8'h70 + 8'(i), 2'(i % 2 == 0 ? 0 : 3), 0, "R7");
    step(1, 8'h7e, 2'd1, 0, "R7");
    step(1, 8'h7f, 2'd0, 0, "R7");
    step(1, 8'h80, 2'd3, 1, "R7");
    for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 1, "R7");
    step(0, 0, 0, 1, "R7");
    do_reset();

    // R5: long wrapping stream
    for (int i = 0; i < 300; i++) begin
      bit ps = ((i * 7) % 5) != 0;
      bit pp = ((i * 3) % 4) != 0 || i > 280;
      step(ps, 8'((i * 37) ^ 8'h5a), 2'((i * 5) % 4), pp, "R5");
    end
    for (int i = 0; i < DEPTH + 1; i++) step(0, 0, 0, 1, "R5");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule